// File: doc/BRIEF.md
# Stack-Frame Call/Return Sequencer

This block runs subroutine linkage on a stack kept in word-addressed memory. It holds the frame pointer and stack pointer. It turns each accepted command into a short series of 32-bit memory accesses. There are five commands: two call forms, a return, a push and a pop. A call stores a 12-byte frame, made of the return address, one reserved word that is never written, and the caller's frame pointer. The call then makes the new frame current. A return does not pop the frame word by word. It rewinds the stack through the frame pointer, restores the caller's frame pointer and hands back the saved program counter.

Commands arrive on a valid/ready channel. `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and a command offered at any other time has no effect. The memory port works as a second handshake. `mem_req` with its address, write enable and write data stays constant until the memory raises `mem_rdy`. A cycle with both signals high completes the access, and read data is sampled in that cycle. When the final access completes, the block pulses `done` for one cycle. A call or return also pulses `redir_valid` in the same cycle, with the new program counter.

Top module: `frame_seq`

## Requirements
- R1: After reset, `frame_ptr` and `stack_ptr` both equal the STACK_TOP parameter (default 0x400), `cmd_ready` is 1, and `mem_req` and `done` are 0.
- R2: A call makes two writes. The first goes to stack_ptr-8 and the second to stack_ptr-12, and the second write carries the old frame_ptr. When the call completes, stack_ptr and frame_ptr both equal the old stack_ptr-12.
- R3: The first write of a call carries the return address. For op 0 (absolute call) this is `cmd_pc`+6. For op 1 (register call) it is `cmd_pc`+2.
- R4: `done` and `redir_valid` rise together when a call completes, and `redir_pc` then equals `cmd_target`.
- R5: Op 2 (return) reads the word at frame_ptr and then the word at frame_ptr+4. When it completes, frame_ptr is the first word read, stack_ptr is the old frame_ptr+12, and `redir_pc` is the second word read, with `redir_valid` high.
- R6: Op 3 (push) writes `cmd_data` to stack_ptr-4, and stack_ptr then becomes stack_ptr-4.
- R7: Op 4 (pop) reads the word at stack_ptr and presents it on `pop_data` when `done` is high. stack_ptr then becomes stack_ptr+4.
- R8: While `mem_req` is high and `mem_rdy` is low, the request, address, write enable and write data keep their values into the next cycle.
- R9: `cmd_ready` is 0 from acceptance until the final access completes. A command offered in that window starts no memory access and does not change either pointer.
- R10: `done` stays high for exactly one cycle. Push and pop never raise `redir_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 3 | 0 absolute call, 1 register call, 2 return, 3 push, 4 pop |
| cmd_pc | input | 32 | Address of the call instruction |
| cmd_target | input | 32 | Call destination |
| cmd_data | input | 32 | Word to push |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_rdy is high |
| mem_rdy | input | 1 | Memory completes the access this cycle |
| redir_valid | output | 1 | One-cycle pulse, new program counter valid |
| redir_pc | output | 32 | New program counter |
| pop_data | output | 32 | Last value popped |
| done | output | 1 | One-cycle pulse, command finished |
| frame_ptr | output | 32 | Current frame pointer |
| stack_ptr | output | 32 | Current stack pointer |

## Verification
The assertions assume the following about the inputs:
- `cmd_op` only carries codes 0 to 4.
- STACK_TOP is word aligned.
- The stack never wraps past address zero.
- `mem_rdata` is meaningful in any cycle where the memory raises `mem_rdy`.

The bench memory meets these conditions. It holds each request for a programmable number of wait cycles, then answers with combinational read data from a word array. The stimulus issues only legal operation codes. Every call is paired with a return, so the stack stays in a small window just below 0x400.

// File: rtl/frame_seq_pkg.sv
`timescale 1ns/1ps
package frame_seq_pkg;

  typedef enum logic [2:0] {
    OP_CALL_ABS = 3'd0,
    OP_CALL_REG = 3'd1,
    OP_RET      = 3'd2,
    OP_PUSH     = 3'd3,
    OP_POP      = 3'd4
  } fs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALL_RA,
    ST_CALL_LINK,
    ST_RET_FP,
    ST_RET_PC,
    ST_PUSH,
    ST_POP
  } fs_state_e;

  // Pointer update requested by the controller for the current cycle
  typedef enum logic [2:0] {
    PU_NONE,
    PU_SP_DN_SLOT,   // sp -= two words
    PU_SP_DN_LINK,   // sp -= one word, fp follows sp
    PU_SP_FROM_FP,   // sp := fp
    PU_FP_RESTORE,   // fp := loaded word, sp += one word
    PU_SP_UP_SLOT,   // sp += two words
    PU_SP_DN_WORD,   // sp -= one word
    PU_SP_UP_WORD    // sp += one word
  } fs_ptr_upd_e;

endpackage

// File: rtl/frame_ptrs.sv
`timescale 1ns/1ps
module frame_ptrs
  import frame_seq_pkg::*;
#(
  parameter int          DW        = 32,
  parameter logic [31:0] STACK_TOP = 32'h0000_0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fs_ptr_upd_e   upd,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] fp,
  output logic [DW-1:0] sp
);

  localparam logic [DW-1:0] WORD_OFS = DW'(DW / 8);
  localparam logic [DW-1:0] SLOT_OFS = DW'(2 * (DW / 8));
  localparam logic [DW-1:0] TOP      = DW'(STACK_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp <= TOP;
      sp <= TOP;
    end else begin
      case (upd)
        PU_SP_DN_SLOT: sp <= sp - SLOT_OFS;
        PU_SP_DN_LINK: begin
          sp <= sp - WORD_OFS;
          fp <= sp - WORD_OFS;
        end
        PU_SP_FROM_FP: sp <= fp;
        PU_FP_RESTORE: begin
          fp <= ld_data;
          sp <= sp + WORD_OFS;
        end
        PU_SP_UP_SLOT: sp <= sp + SLOT_OFS;
        PU_SP_DN_WORD: sp <= sp - WORD_OFS;
        PU_SP_UP_WORD: sp <= sp + WORD_OFS;
        default: ;
      endcase
    end
  end

  // R2: linking a frame leaves both pointers on the same word
  p_frame_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd == PU_SP_DN_LINK) |=> (fp == sp));

  // R5: the saved frame pointer becomes current after the first return read
  p_fp_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd == PU_FP_RESTORE) |=> (fp == $past(ld_data)));

  // R5: rewinding copies the frame pointer into the stack pointer
  p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd == PU_SP_FROM_FP) |=> (sp == $past(fp)));

endmodule

// File: rtl/frame_agen.sv
`timescale 1ns/1ps
module frame_agen
  import frame_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  fs_state_e     state,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] fp,
  input  logic [DW-1:0] ret_addr,
  input  logic [DW-1:0] push_val,
  output logic          req,
  output logic          we,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wdata
);

  localparam logic [DW-1:0] WORD_OFS = DW'(DW / 8);
  localparam logic [DW-1:0] SLOT_OFS = DW'(2 * (DW / 8));

  always_comb begin
    req   = (state != ST_IDLE);
    we    = 1'b0;
    addr  = sp;
    wdata = '0;
    case (state)
      ST_CALL_RA: begin
        we    = 1'b1;
        addr  = sp - SLOT_OFS;
        wdata = ret_addr;
      end
      ST_CALL_LINK: begin
        we    = 1'b1;
        addr  = sp - WORD_OFS;
        wdata = fp;
      end
      ST_PUSH: begin
        we    = 1'b1;
        addr  = sp - WORD_OFS;
        wdata = push_val;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/frame_ctrl.sv
`timescale 1ns/1ps
module frame_ctrl
  import frame_seq_pkg::*;
#(
  parameter int DW         = 32,
  parameter int ABS_CALL_B = 6,
  parameter int REG_CALL_B = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_pc,
  input  logic [DW-1:0] cmd_target,
  input  logic [DW-1:0] cmd_data,
  input  logic          mem_rdy,
  input  logic [DW-1:0] mem_rdata,
  output logic          cmd_ready,
  output fs_state_e     state,
  output logic [DW-1:0] ret_addr,
  output logic [DW-1:0] push_val,
  output fs_ptr_upd_e   ptr_upd,
  output logic          done,
  output logic          redir,
  output logic [DW-1:0] redir_pc,
  output logic [DW-1:0] pop_data
);

  fs_state_e     nxt;
  fs_op_e        op;
  logic          accept;
  logic          xfer;
  logic          last_xfer;
  logic [DW-1:0] tgt_q;

  assign op        = fs_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign xfer      = (state != ST_IDLE) && mem_rdy;
  assign last_xfer = xfer && (state inside {ST_CALL_LINK, ST_RET_PC, ST_PUSH, ST_POP});

  always_comb begin
    nxt     = state;
    ptr_upd = PU_NONE;
    case (state)
      ST_IDLE: if (accept) begin
        case (op)
          OP_CALL_ABS, OP_CALL_REG: nxt = ST_CALL_RA;
          OP_RET: begin
            nxt     = ST_RET_FP;
            ptr_upd = PU_SP_FROM_FP;
          end
          OP_PUSH: nxt = ST_PUSH;
          OP_POP:  nxt = ST_POP;
          default: nxt = ST_IDLE;
        endcase
      end
      ST_CALL_RA:   if (xfer) begin nxt = ST_CALL_LINK; ptr_upd = PU_SP_DN_SLOT; end
      ST_CALL_LINK: if (xfer) begin nxt = ST_IDLE;      ptr_upd = PU_SP_DN_LINK; end
      ST_RET_FP:    if (xfer) begin nxt = ST_RET_PC;    ptr_upd = PU_FP_RESTORE; end
      ST_RET_PC:    if (xfer) begin nxt = ST_IDLE;      ptr_upd = PU_SP_UP_SLOT; end
      ST_PUSH:      if (xfer) begin nxt = ST_IDLE;      ptr_upd = PU_SP_DN_WORD; end
      ST_POP:       if (xfer) begin nxt = ST_IDLE;      ptr_upd = PU_SP_UP_WORD; end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ret_addr <= '0;
      push_val <= '0;
      tgt_q    <= '0;
      done     <= 1'b0;
      redir    <= 1'b0;
      redir_pc <= '0;
      pop_data <= '0;
    end else begin
      state <= nxt;
      done  <= last_xfer;
      redir <= xfer && (state inside {ST_CALL_LINK, ST_RET_PC});
      if (accept) begin
        ret_addr <= cmd_pc + DW'((op == OP_CALL_ABS) ? ABS_CALL_B : REG_CALL_B);
        tgt_q    <= cmd_target;
        push_val <= cmd_data;
      end
      if (xfer && state == ST_CALL_LINK) redir_pc <= tgt_q;
      if (xfer && state == ST_RET_PC)    redir_pc <= mem_rdata;
      if (xfer && state == ST_POP)       pop_data <= mem_rdata;
    end
  end

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: a redirect never appears without completion
  p_redir_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redir |-> done);

  // R10: push and pop finish without redirecting
  p_stack_noredir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (state inside {ST_PUSH, ST_POP})) |=> (done && !redir));

  // R9: an accepted command leaves the channel closed on the next cycle
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op inside {OP_CALL_ABS, OP_CALL_REG, OP_RET, OP_PUSH, OP_POP})
      |=> !cmd_ready);

endmodule

// File: rtl/frame_seq.sv
`timescale 1ns/1ps
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [31:0] STACK_TOP  = 32'h0000_0400,
  parameter int          ABS_CALL_B = 6,
  parameter int          REG_CALL_B = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_pc,
  input  logic [DW-1:0] cmd_target,
  input  logic [DW-1:0] cmd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          redir_valid,
  output logic [DW-1:0] redir_pc,
  output logic [DW-1:0] pop_data,
  output logic          done,
  output logic [DW-1:0] frame_ptr,
  output logic [DW-1:0] stack_ptr
);

  fs_state_e     state;
  fs_ptr_upd_e   ptr_upd;
  logic [DW-1:0] ret_addr;
  logic [DW-1:0] push_val;

  frame_ctrl #(
    .DW(DW), .ABS_CALL_B(ABS_CALL_B), .REG_CALL_B(REG_CALL_B)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_pc     (cmd_pc),
    .cmd_target (cmd_target),
    .cmd_data   (cmd_data),
    .mem_rdy    (mem_rdy),
    .mem_rdata  (mem_rdata),
    .cmd_ready  (cmd_ready),
    .state      (state),
    .ret_addr   (ret_addr),
    .push_val   (push_val),
    .ptr_upd    (ptr_upd),
    .done       (done),
    .redir      (redir_valid),
    .redir_pc   (redir_pc),
    .pop_data   (pop_data)
  );

  frame_ptrs #(.DW(DW), .STACK_TOP(STACK_TOP)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (ptr_upd),
    .ld_data (mem_rdata),
    .fp      (frame_ptr),
    .sp      (stack_ptr)
  );

  frame_agen #(.DW(DW)) u_agen (
    .state    (state),
    .sp       (stack_ptr),
    .fp       (frame_ptr),
    .ret_addr (ret_addr),
    .push_val (push_val),
    .req      (mem_req),
    .we       (mem_we),
    .addr     (mem_addr),
    .wdata    (mem_wdata)
  );

  // R8: a stalled request holds every field into the next cycle
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9: no memory traffic while the command channel is open
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);

  // R2: pointers stay word aligned under the aligned-top assumption
  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_ptr[1:0] == 2'b00) && (frame_ptr[1:0] == 2'b00));

endmodule

// File: tb/test_frame_seq.sv
`timescale 1ns/1ps
module test_frame_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_pc, cmd_target, cmd_data;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        redir_valid, done;
  logic [31:0] redir_pc, pop_data, frame_ptr, stack_ptr;

  always #2.5 clk = ~clk;

  frame_seq i_frame_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .cmd_target(cmd_target), .cmd_data(cmd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .pop_data(pop_data), .done(done),
    .frame_ptr(frame_ptr), .stack_ptr(stack_ptr)
  );

  // Memory model with programmable wait states
  logic [31:0] mem [0:255];
  int          wait_cfg = 0;
  int          wcnt;
  assign mem_rdy   = mem_req && (wcnt == wait_cfg);
  assign mem_rdata = mem[mem_addr[9:2]];

  logic [31:0] log_addr [0:63];
  logic        log_we   [0:63];
  logic [31:0] log_wd   [0:63];
  int          log_n = 0;

  always @(posedge clk) begin
    if (!rst_n || !mem_req || mem_rdy) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (rst_n && mem_req && mem_rdy) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      if (log_n < 64) begin
        log_addr[log_n] <= mem_addr;
        log_we[log_n]   <= mem_we;
        log_wd[log_n]   <= mem_wdata;
        log_n           <= log_n + 1;
      end
    end
  end

  // Back-pressure monitor for R8
  int          bp_err = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr, prev_wd;
  logic        prev_we;
  always @(negedge clk) begin
    if (rst_n && prev_wait &&
        (!mem_req || mem_addr != prev_addr || mem_wdata != prev_wd || mem_we != prev_we))
      bp_err++;
    prev_wait = rst_n && mem_req && !mem_rdy;
    prev_addr = mem_addr;
    prev_wd   = mem_wdata;
    prev_we   = mem_we;
  end

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_sp, exp_fp;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] pc,
                       input logic [31:0] tgt, input logic [31:0] dat);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_target = tgt; cmd_data = dat;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(req, "done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic after_done(input string req);
    @(negedge clk);
    chk(req, "done single cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "frame_ptr", frame_ptr, 32'h400);
    chk("R1", "stack_ptr", stack_ptr, 32'h400);
    chk("R1", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_call(input logic abs_form, input logic [31:0] pc,
                        input logic [31:0] tgt, input int wt);
    int base = log_n;
    logic [31:0] old_sp = exp_sp;
    wait_cfg = wt;
    issue(abs_form ? 3'd0 : 3'd1, pc, tgt, 32'h0);
    wait_done("R4");
    chk("R2", "access count", log_n - base, 2);
    chk("R2", "ra write addr", log_addr[base], old_sp - 8);
    chk("R2", "ra is write", {31'd0, log_we[base]}, 32'd1);
    chk("R3", "return address", log_wd[base], pc + (abs_form ? 32'd6 : 32'd2));
    chk("R2", "link write addr", log_addr[base+1], old_sp - 12);
    chk("R2", "link data", log_wd[base+1], exp_fp);
    chk("R2", "stack_ptr", stack_ptr, old_sp - 12);
    chk("R2", "frame_ptr", frame_ptr, old_sp - 12);
    chk("R4", "redir_valid", {31'd0, redir_valid}, 32'd1);
    chk("R4", "redir_pc", redir_pc, tgt);
    exp_sp = old_sp - 12;
    exp_fp = old_sp - 12;
    after_done("R10");
  endtask

  task automatic t_ret(input logic [31:0] exp_pc, input logic [31:0] exp_newfp,
                       input int wt);
    int base = log_n;
    logic [31:0] f = exp_fp;
    wait_cfg = wt;
    issue(3'd2, 32'h0, 32'h0, 32'h0);
    wait_done("R5");
    chk("R5", "access count", log_n - base, 2);
    chk("R5", "fp read addr", log_addr[base], f);
    chk("R5", "pc read addr", log_addr[base+1], f + 4);
    chk("R5", "reads", {30'd0, log_we[base], log_we[base+1]}, 32'd0);
    chk("R5", "frame_ptr", frame_ptr, exp_newfp);
    chk("R5", "stack_ptr", stack_ptr, f + 12);
    chk("R5", "redir_valid", {31'd0, redir_valid}, 32'd1);
    chk("R5", "redir_pc", redir_pc, exp_pc);
    exp_sp = f + 12;
    exp_fp = exp_newfp;
    after_done("R10");
  endtask

  task automatic t_push(input logic [31:0] val, input int wt);
    int base = log_n;
    wait_cfg = wt;
    issue(3'd3, 32'h0, 32'h0, val);
    wait_done("R6");
    chk("R6", "access count", log_n - base, 1);
    chk("R6", "push addr", log_addr[base], exp_sp - 4);
    chk("R6", "push data", log_wd[base], val);
    chk("R6", "stack_ptr", stack_ptr, exp_sp - 4);
    chk("R10", "no redirect on push", {31'd0, redir_valid}, 32'd0);
    exp_sp = exp_sp - 4;
    after_done("R10");
  endtask

  task automatic t_pop(input logic [31:0] val, input int wt);
    int base = log_n;
    wait_cfg = wt;
    issue(3'd4, 32'h0, 32'h0, 32'h0);
    wait_done("R7");
    chk("R7", "pop addr", log_addr[base], exp_sp);
    chk("R7", "pop is read", {31'd0, log_we[base]}, 32'd0);
    chk("R7", "pop_data", pop_data, val);
    chk("R7", "stack_ptr", stack_ptr, exp_sp + 4);
    chk("R10", "no redirect on pop", {31'd0, redir_valid}, 32'd0);
    exp_sp = exp_sp + 4;
    after_done("R10");
  endtask

  // Push under long waits while a pop is offered during the busy window
  task automatic t_busy_ignore(input logic [31:0] val);
    int base = log_n;
    wait_cfg = 4;
    issue(3'd3, 32'h0, 32'h0, val);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    for (int k = 0; k < 3; k++) begin
      chk("R9", "cmd_ready while busy", {31'd0, cmd_ready}, 32'd0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_done("R9");
    chk("R9", "one access only", log_n - base, 1);
    chk("R9", "stack_ptr", stack_ptr, exp_sp - 4);
    exp_sp = exp_sp - 4;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "no further request", {31'd0, mem_req}, 32'd0);
    chk("R9", "stack_ptr unchanged", stack_ptr, exp_sp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
    cmd_pc = '0; cmd_target = '0; cmd_data = '0;
    exp_sp = 32'h400; exp_fp = 32'h400;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call(1'b1, 32'h100, 32'h2000, 0);
    t_push(32'hDEAD_BEEF, 2);
    t_pop(32'hDEAD_BEEF, 1);
    t_call(1'b0, 32'h2010, 32'h3000, 3);
    t_busy_ignore(32'h1234_5678);
    t_pop(32'h1234_5678, 0);
    t_ret(32'h2012, 32'h3F4, 1);
    t_ret(32'h106, 32'h400, 0);
    chk("R8", "stalled request changed", bp_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule